// File: doc/BRIEF.md
# Prescaled PWM with Committed Shadow Registers

This block generates a single pulse-width-modulated output, such as a backlight drive. A programmable prescaler divides the input clock into ticks. A period counter counts ticks to form each PWM cycle. The output is high for a programmable number of ticks at the start of every cycle.

Software programs the divider, the period and the high width through a small register port. These writes land in shadow copies and do not reach the counters at once. A commit pulse moves all three shadow values together into the active set. While the output runs, the active set changes only at the next cycle boundary. A manual mode instead lets the shadow copies drive the counters directly. Software can read back both the shadow and the active values, and from these it can rebuild the period and duty of the output.

Top module: `prescaled_pwm`

## Requirements
- R1: The divider field is 10 bits at bits [25:16] of the control-0 register (byte address 0x04). One tick lasts divider+1 clocks. The period field is 12 bits at bits [11:0] of the control-1 register (0x08). One PWM cycle lasts period+1 ticks.
- R2: The high-width field is 13 bits at bits [28:16] of control-1. In each cycle the output is high for the first width ticks and low for the remaining ticks.
- R3: If the width is greater than the period, the output stays high for the whole cycle. If the width is 0, the output stays low.
- R4: Bit 0 of the commit register (0x0C) causes a transfer only when a write sets it while it holds 0. Such a write copies divider, period and width from shadow to active together. Writing the shadow registers alone, or writing 1 while the bit is already 1, leaves the active values unchanged.
- R5: While the output is enabled, committed values take effect at the next cycle boundary, so the cycle in progress completes with its old values. While disabled, a commit loads the active values at the write edge.
- R6: Manual mode requires two things: the select bit (bit 1 of control-0) must be set, and the bypass field (bits [1:0] at 0x10) must equal 3. In manual mode the active values follow the shadow values one clock later, with no commit. Either condition alone has no effect.
- R7: Bit 0 of the enable register (0x00) gates the output. While it is clear, the output is low and both counters hold at zero. When it is set, the next cycle starts from tick 0 with the high phase.
- R8: Reads of 0x00, 0x04, 0x08, 0x0C and 0x10 return the stored fields. Reads of 0x14 and 0x18 return the active divider and the active period/width, in the same bit positions as control-0 and control-1. All other bits, and unmapped addresses, read as zero. Read data is combinational from the read address.
- R9: Reset clears all shadow and active values, the enable bit, the commit bit and the mode bits, and holds the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| wrAddr | input | 8 | Write byte address |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read byte address |
| rdData | output | 32 | Read data for rdAddr |
| pwmOut | output | 1 | PWM output |

## Verification
A register write takes effect at the clock edge that captures it, and read data follows the read address with no delay. When an enable write is captured, the first sample after that edge is tick 0 of cycle 0. Every sample after that has an expected level given by its offset t: the output should be high when (t / (divider+1)) mod (period+1) is less than the width. The bench queues these levels at the capture edge, and a monitor compares one level per falling edge. For a commit made during a cycle, the bench keeps the old settings for the rest of that cycle and queues the new settings from the following boundary. Manual-mode and disabled-commit results are read one clock after the capture edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DIV_W   = 10;
  localparam int PER_W   = 12;
  localparam int WID_W   = 13;
  localparam int BYP_W   = 2;
  localparam int DIV_LSB = 16;
  localparam int WID_LSB = 16;
  localparam int SEL_BIT = 1;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] ADR_EN   = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_CTL0 = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_CTL1 = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_COM  = 8'h0C;
  localparam logic [ADDR_W-1:0] ADR_BYP  = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_ACT0 = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_ACT1 = 8'h18;

  typedef struct packed {
    logic             enable;
    logic             manual;
    logic             commitReq;
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [WID_W-1:0] wid;
  } pwmCtl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [DIV_W-1:0]  actDiv,
  input  logic [PER_W-1:0]  actPer,
  input  logic [WID_W-1:0]  actWid,
  output pwmCtl_t           ctl
);
  logic             enR, selR, comR;
  logic [BYP_W-1:0] bypR;
  logic [DIV_W-1:0] divR;
  logic [PER_W-1:0] perR;
  logic [WID_W-1:0] widR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enR  <= 1'b0;
      selR <= 1'b0;
      comR <= 1'b0;
      bypR <= '0;
      divR <= '0;
      perR <= '0;
      widR <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADR_EN:   enR <= wrData[0];
        ADR_CTL0: begin
          divR <= wrData[DIV_LSB +: DIV_W];
          selR <= wrData[SEL_BIT];
        end
        ADR_CTL1: begin
          perR <= wrData[0 +: PER_W];
          widR <= wrData[WID_LSB +: WID_W];
        end
        ADR_COM:  comR <= wrData[0];
        ADR_BYP:  bypR <= wrData[BYP_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    ctl.enable    = enR;
    ctl.manual    = selR && (bypR == {BYP_W{1'b1}});
    ctl.commitReq = wrEn && (wrAddr == ADR_COM) && wrData[0] && !comR;
    ctl.div       = divR;
    ctl.per       = perR;
    ctl.wid       = widR;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_EN:   rdData[0] = enR;
      ADR_CTL0: begin
        rdData[DIV_LSB +: DIV_W] = divR;
        rdData[SEL_BIT]          = selR;
      end
      ADR_CTL1: begin
        rdData[0 +: PER_W]       = perR;
        rdData[WID_LSB +: WID_W] = widR;
      end
      ADR_COM:  rdData[0] = comR;
      ADR_BYP:  rdData[BYP_W-1:0] = bypR;
      ADR_ACT0: rdData[DIV_LSB +: DIV_W] = actDiv;
      ADR_ACT1: begin
        rdData[0 +: PER_W]       = actPer;
        rdData[WID_LSB +: WID_W] = actWid;
      end
      default:  ;
    endcase
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pwmCtl_t          ctl,
  output logic             pwmOut,
  output logic [DIV_W-1:0] actDiv,
  output logic [PER_W-1:0] actPer,
  output logic [WID_W-1:0] actWid,
  output logic             cycStart
);
  logic [DIV_W-1:0] preCnt, pendDiv;
  logic [PER_W-1:0] perCnt, pendPer;
  logic [WID_W-1:0] pendWid;
  logic             pendFlag;
  logic             tick, wrap;

  assign tick     = (preCnt == actDiv);
  assign wrap     = tick && (perCnt == actPer);
  assign cycStart = (preCnt == '0) && (perCnt == '0);
  assign pwmOut   = ctl.enable && (WID_W'(perCnt) < actWid);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (!ctl.enable) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      perCnt <= wrap ? '0 : perCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actDiv   <= '0;
      actPer   <= '0;
      actWid   <= '0;
      pendDiv  <= '0;
      pendPer  <= '0;
      pendWid  <= '0;
      pendFlag <= 1'b0;
    end else if (ctl.manual || (ctl.commitReq && !ctl.enable)) begin
      actDiv   <= ctl.div;
      actPer   <= ctl.per;
      actWid   <= ctl.wid;
      pendFlag <= 1'b0;
    end else if (ctl.commitReq) begin
      pendDiv  <= ctl.div;
      pendPer  <= ctl.per;
      pendWid  <= ctl.wid;
      pendFlag <= 1'b1;
    end else if (pendFlag && (wrap || !ctl.enable)) begin
      actDiv   <= pendDiv;
      actPer   <= pendPer;
      actWid   <= pendWid;
      pendFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut
);
  pwmCtl_t          ctl;
  logic [DIV_W-1:0] actDiv;
  logic [PER_W-1:0] actPer;
  logic [WID_W-1:0] actWid;
  logic             cycStart;

  pwm_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .actDiv(actDiv), .actPer(actPer), .actWid(actWid), .ctl(ctl)
  );

  pwm_core u_core (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pwmOut(pwmOut),
    .actDiv(actDiv), .actPer(actPer), .actWid(actWid), .cycStart(cycStart)
  );
endmodule

// File: rtl/prescaled_pwm_chk.sv
module prescaled_pwm_chk
  import pwm_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             pwmOut,
  input pwmCtl_t          ctl,
  input logic [DIV_W-1:0] actDiv,
  input logic [PER_W-1:0] actPer,
  input logic [WID_W-1:0] actWid,
  input logic             cycStart
);
  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.enable |-> !pwmOut);

  // R3
  full_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && (actWid > WID_W'(actPer))) |-> pwmOut);

  // R3
  zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actWid == '0) |-> !pwmOut);

  // R6
  manual_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.manual |=> (actDiv == $past(ctl.div)) && (actPer == $past(ctl.per))
                   && (actWid == $past(ctl.wid)));

  // R5
  idle_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commitReq && !ctl.enable) |=> (actDiv == $past(ctl.div))
                   && (actPer == $past(ctl.per)) && (actWid == $past(ctl.wid)));

  // R5
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && $past(ctl.enable) && !ctl.manual && !$past(ctl.manual)
     && (!$stable(actDiv) || !$stable(actPer) || !$stable(actWid))) |-> cycStart);
endmodule

bind prescaled_pwm prescaled_pwm_chk u_chk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .ctl(ctl),
  .actDiv(actDiv), .actPer(actPer), .actWid(actWid), .cycStart(cycStart)
);

// File: tb/tb_prescaled_pwm.sv
module tb_prescaled_pwm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        pwmOut;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;
  bit expQ[$];
  string tagQ[$];

  prescaled_pwm dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] c0(int d, int sel);
    return (32'(d) << 16) | (32'(sel) << 1);
  endfunction
  function automatic logic [31:0] c1(int p, int w);
    return (32'(w) << 16) | 32'(p);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    rdAddr = a; #1;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdData, exp);
    end
  endtask

  task automatic pushWave(input int d, input int p, input int w, input int t0,
                          input int n, input string tag);
    for (int t = t0; t < t0 + n; t++) begin
      expQ.push_back(((t / (d + 1)) % (p + 1)) < w);
      tagQ.push_back(tag);
    end
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic commit();
    wr(8'h0C, 32'h1);
    wr(8'h0C, 32'h0);
  endtask

  // monitor: one expected level per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      bit e;
      string tg;
      e = expQ.pop_front();
      tg = tagQ.pop_front();
      total++;
      if (pwmOut !== e) begin
        bad++;
        $display("FAIL %s pwmOut actual=%b expected=%b", tg, pwmOut, e);
      end
    end
  end

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9 reset state
    total++;
    if (pwmOut !== 1'b0) begin
      bad++;
      $display("FAIL R9 pwmOut actual=%b expected=0", pwmOut);
    end
    rdChk(8'h00, 32'h0, "R9 enable");
    rdChk(8'h04, 32'h0, "R9 ctl0");
    rdChk(8'h08, 32'h0, "R9 ctl1");
    rdChk(8'h18, 32'h0, "R9 act1");

    // R8 reserved bits read zero
    wr(8'h04, 32'hFFFF_FFFF);
    rdChk(8'h04, 32'h03FF_0002, "R8 ctl0 fields");
    wr(8'h08, 32'hFFFF_FFFF);
    rdChk(8'h08, 32'h1FFF_0FFF, "R8 ctl1 fields");
    rdChk(8'h40, 32'h0, "R8 unmapped");
    rdChk(8'h18, 32'h0, "R4 shadow write alone");

    // R4 / R5 commit while disabled applies immediately
    wr(8'h04, c0(1, 0));
    wr(8'h08, c1(3, 2));
    wr(8'h0C, 32'h1);
    rdChk(8'h14, c0(1, 0), "R5 idle commit act0");
    rdChk(8'h18, c1(3, 2), "R4 idle commit act1");
    wr(8'h08, c1(7, 7));
    wr(8'h0C, 32'h1);
    rdChk(8'h18, c1(3, 2), "R4 no rearm");
    wr(8'h0C, 32'h0);
    wr(8'h08, c1(3, 2));
    rdChk(8'h18, c1(3, 2), "R4 after clear");

    // R1 R2 R7 wave, then R5 commit mid-cycle
    wr(8'h00, 32'h1);
    pushWave(1, 3, 2, 0, 8, "R1 R2 first cycle");
    wr(8'h04, c0(0, 0));
    wr(8'h08, c1(4, 1));
    commit();
    pushWave(0, 4, 1, 0, 15, "R5 boundary switch");
    drain();
    rdChk(8'h18, c1(4, 1), "R5 act1 applied");

    // R7 disable holds low, re-enable restarts with high phase
    wr(8'h00, 32'h0);
    pushWave(0, 0, 0, 0, 10, "R7 disabled low");
    drain();
    wr(8'h04, c0(2, 0));
    wr(8'h08, c1(2, 1));
    commit();
    wr(8'h00, 32'h1);
    pushWave(2, 2, 1, 0, 27, "R7 R1 restart");
    drain();

    // R3 full high: width == period+1, then width > period
    wr(8'h00, 32'h0);
    wr(8'h08, c1(3, 4));
    commit();
    wr(8'h00, 32'h1);
    pushWave(0, 0, 1, 0, 30, "R3 width=period+1");
    wr(8'h08, c1(3, 100));
    commit();
    drain();
    rdChk(8'h18, c1(3, 100), "R3 wide committed");
    total++;
    if (pwmOut !== 1'b1) begin
      bad++;
      $display("FAIL R3 wide pwmOut actual=%b expected=1", pwmOut);
    end

    // R3 zero width
    wr(8'h00, 32'h0);
    wr(8'h08, c1(3, 0));
    commit();
    wr(8'h00, 32'h1);
    pushWave(2, 3, 0, 0, 30, "R3 width zero");
    drain();
    wr(8'h00, 32'h0);

    // R6 manual mode
    wr(8'h10, 32'h3);
    wr(8'h08, c1(5, 3));
    rdChk(8'h18, c1(3, 0), "R6 bypass alone no effect");
    wr(8'h10, 32'h1);
    wr(8'h04, c0(5, 1));
    rdChk(8'h14, c0(2, 0), "R6 select alone no effect");
    wr(8'h10, 32'h3);
    rdChk(8'h14, c0(5, 0), "R6 manual act0");
    rdChk(8'h18, c1(5, 3), "R6 manual act1");
    rdChk(8'h10, 32'h3, "R8 bypass readback");
    wr(8'h08, c1(9, 4));
    rdChk(8'h18, c1(9, 4), "R6 manual follows");

    finishRun();
  end
endmodule